// File: doc/BRIEF.md
# Stereo output attenuation and mute control register

This block holds the volume and mute settings for a stereo audio output path. Software writes it through a simple indexed port: a register index, 16 bits of write data and a write strobe. A separate read index returns the stored image on a 16-bit read bus. The block keeps one 5-bit attenuation code per channel, in 1.5 dB steps from 0 dB (code 0) to 46.5 dB (code 31). It also keeps a master mute bit and a right mute bit.

Two configuration inputs shape how the stored settings are interpreted:
- `split_mute` chooses between one global mute and separate left and right mutes.
- `ext_route` extends the same settings to the center output, which follows the left channel, and to the LFE output, which follows the right channel.

A write that sets the sixth bit of a volume field is folded to the 5-bit maximum, and the folded value is what reads back. Each output gets a 5-bit attenuation code and a mute flag. A muted output is driven to code 31 with its mute flag set, so the downstream attenuator treats it as fully silent.

Top module: `volmute_reg`

## Requirements
- R1: After reset the register reads 0x8000 at index 0x02, and both line-out outputs have the mute flag set.
- R2: A write to index 0x02 stores the following fields:
  - bit 15: master mute
  - bits 13:8: left volume
  - bit 7: right mute
  - bits 5:0: right volume

  Reading index 0x02 returns those fields in the same positions. Bits 14 and 6 always read 0.
- R3: If a write has bit 13 (or bit 5) set, the left (or right) volume field is stored and read back as 01_1111. The matching output attenuation code is then 31.
- R4: When `split_mute` is 0, bit 7 reads back as 0. The stored bit 7 is kept and reads back again once `split_mute` returns to 1, with no rewrite.
- R5: When `split_mute` is 0, bit 15 = 1 mutes both line-out channels, and bit 7 has no effect on any output.
- R6: When `split_mute` is 1, bit 15 mutes only the left-side outputs and bit 7 mutes only the right-side outputs, each independently of the other.
- R7: An unmuted output carries its channel's 5-bit code from bits 4:0 of the field. A muted output carries code 31 with its mute flag at 1, whatever its volume bits hold.
- R8: When `ext_route` is 0, the center and LFE outputs carry code 0 and are unmuted. When it is 1, center follows the left channel's code and mute, and LFE follows the right channel's.
- R9: Writes to any index other than 0x02 leave the register unchanged. Reads of any other index return 0x0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| wr_en | input | 1 | Write strobe |
| wr_idx | input | 8 | Write register index |
| wr_data | input | 16 | Write data |
| rd_idx | input | 8 | Read register index |
| rd_data | output | 16 | Read data (combinational) |
| split_mute | input | 1 | 1 = separate left and right mutes |
| ext_route | input | 1 | 1 = center and LFE also follow this register |
| lo_l_att | output | 5 | Line-out left attenuation code |
| lo_l_mute | output | 1 | Line-out left mute |
| lo_r_att | output | 5 | Line-out right attenuation code |
| lo_r_mute | output | 1 | Line-out right mute |
| ctr_att | output | 5 | Center attenuation code |
| ctr_mute | output | 1 | Center mute |
| lfe_att | output | 5 | LFE attenuation code |
| lfe_mute | output | 1 | LFE mute |

## Verification
The bench writes out-of-range volume fields on each channel separately. A design that failed to fold them would read back 1x_xxxx, or emit a small code instead of 31. It toggles `split_mute` without rewriting the register, which catches two faults:
- a design that clears the stored right mute, so bit 7 fails to reappear;
- a design that lets bit 7 mute the right channel in joint mode.

With split mute on, it mutes one side at a time; a design that mixed up the sides would silence the wrong channel. It also flips `ext_route`, writes and reads other indices, and confirms that muted outputs show code 31 rather than the stored volume.

// File: rtl/volmute_pkg.sv
package volmute_pkg;
  localparam int ATT_W   = 5;
  localparam int FIELD_W = ATT_W + 1;
  localparam int DATA_W  = 16;
  localparam int IDX_W   = 8;
  localparam int N_OUT   = 4;

  typedef struct packed {
    logic             mute;
    logic [ATT_W-1:0] att;
  } chan_t;
endpackage

// File: rtl/volmute_fold.sv
module volmute_fold
  import volmute_pkg::*;
(
  input  logic [FIELD_W-1:0] raw,
  output logic [FIELD_W-1:0] folded
);
  always_comb begin
    if (raw[FIELD_W-1]) folded = {1'b0, {ATT_W{1'b1}}};
    else                folded = raw;
  end
endmodule

// File: rtl/volmute_chan.sv
module volmute_chan
  import volmute_pkg::*;
(
  input  logic             en,
  input  logic             mute,
  input  logic [ATT_W-1:0] code,
  output chan_t            out
);
  always_comb begin
    if (!en)       out = '{mute: 1'b0, att: '0};
    else if (mute) out = '{mute: 1'b1, att: {ATT_W{1'b1}}};
    else           out = '{mute: 1'b0, att: code};
  end
endmodule

// File: rtl/volmute_reg.sv
module volmute_reg
  import volmute_pkg::*;
#(
  parameter logic [IDX_W-1:0] REG_IDX = 8'h02
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [DATA_W-1:0] rd_data,
  input  logic              split_mute,
  input  logic              ext_route,
  output logic [ATT_W-1:0]  lo_l_att,
  output logic              lo_l_mute,
  output logic [ATT_W-1:0]  lo_r_att,
  output logic              lo_r_mute,
  output logic [ATT_W-1:0]  ctr_att,
  output logic              ctr_mute,
  output logic [ATT_W-1:0]  lfe_att,
  output logic              lfe_mute
);
  localparam int L_LO = 8;
  localparam int R_LO = 0;
  localparam int MM_BIT = 15;
  localparam int RM_BIT = 7;

  logic               mm_q, mm_d;
  logic               rm_q, rm_d;
  logic [FIELD_W-1:0] vl_q, vl_d;
  logic [FIELD_W-1:0] vr_q, vr_d;
  logic [FIELD_W-1:0] vl_fold, vr_fold;
  logic               hit;

  volmute_fold u_fold_l (.raw(wr_data[L_LO +: FIELD_W]), .folded(vl_fold));
  volmute_fold u_fold_r (.raw(wr_data[R_LO +: FIELD_W]), .folded(vr_fold));

  assign hit = wr_en && (wr_idx == REG_IDX);

  always_comb begin
    mm_d = mm_q;
    rm_d = rm_q;
    vl_d = vl_q;
    vr_d = vr_q;
    if (hit) begin
      mm_d = wr_data[MM_BIT];
      rm_d = wr_data[RM_BIT];
      vl_d = vl_fold;
      vr_d = vr_fold;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mm_q <= 1'b1;
      rm_q <= 1'b0;
      vl_q <= '0;
      vr_q <= '0;
    end else if (hit) begin
      mm_q <= mm_d;
      rm_q <= rm_d;
      vl_q <= vl_d;
      vr_q <= vr_d;
    end
  end

  // readback image
  always_comb begin
    rd_data = '0;
    if (rd_idx == REG_IDX) begin
      rd_data[MM_BIT]             = mm_q;
      rd_data[L_LO +: FIELD_W]    = vl_q;
      rd_data[RM_BIT]             = rm_q & split_mute;
      rd_data[R_LO +: FIELD_W]    = vr_q;
    end
  end

  // mute decode
  logic mute_left, mute_right;
  always_comb begin
    mute_left  = mm_q;
    mute_right = split_mute ? rm_q : mm_q;
  end

  // outputs: 0 = line-out L, 1 = line-out R, 2 = center, 3 = LFE
  logic             src_en   [N_OUT];
  logic             src_mute [N_OUT];
  logic [ATT_W-1:0] src_code [N_OUT];
  chan_t            outs     [N_OUT];

  genvar gi;
  generate
    for (gi = 0; gi < N_OUT; gi++) begin : g_out
      localparam bit IS_LEFT = (gi % 2) == 0;
      localparam bit IS_EXT  = gi >= 2;
      assign src_en[gi]   = IS_EXT ? ext_route : 1'b1;
      assign src_mute[gi] = IS_LEFT ? mute_left : mute_right;
      assign src_code[gi] = IS_LEFT ? vl_q[ATT_W-1:0] : vr_q[ATT_W-1:0];
      volmute_chan u_chan (
        .en  (src_en[gi]),
        .mute(src_mute[gi]),
        .code(src_code[gi]),
        .out (outs[gi])
      );
    end
  endgenerate

  assign lo_l_att  = outs[0].att;
  assign lo_l_mute = outs[0].mute;
  assign lo_r_att  = outs[1].att;
  assign lo_r_mute = outs[1].mute;
  assign ctr_att   = outs[2].att;
  assign ctr_mute  = outs[2].mute;
  assign lfe_att   = outs[3].att;
  assign lfe_mute  = outs[3].mute;
endmodule

// File: rtl/volmute_reg_chk.sv
module volmute_reg_chk
  import volmute_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [IDX_W-1:0]  wr_idx,
  input logic [DATA_W-1:0] wr_data,
  input logic [IDX_W-1:0]  rd_idx,
  input logic [DATA_W-1:0] rd_data,
  input logic              split_mute,
  input logic              ext_route,
  input logic [ATT_W-1:0]  lo_l_att,
  input logic              lo_l_mute,
  input logic [ATT_W-1:0]  lo_r_att,
  input logic              lo_r_mute,
  input logic [ATT_W-1:0]  ctr_att,
  input logic              ctr_mute,
  input logic [ATT_W-1:0]  lfe_att,
  input logic              lfe_mute
);
  // R2
  unused_bits_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data[14] == 1'b0) && (rd_data[6] == 1'b0));

  // R3
  left_fold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_idx == 8'h02 && wr_data[13] && rd_idx == 8'h02)
      |=> (rd_idx != 8'h02) || (rd_data[13:8] == 6'h1f));

  // R4
  rmute_hidden_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !split_mute |-> !rd_data[7]);

  // R5
  joint_mute_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !split_mute |-> (lo_l_mute == lo_r_mute));

  // R7
  muted_full_att_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lo_l_mute |-> lo_l_att == 5'd31) and (lo_r_mute |-> lo_r_att == 5'd31));

  // R8
  ext_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ext_route |-> (ctr_att == '0 && !ctr_mute && lfe_att == '0 && !lfe_mute));

  // R8
  ext_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ext_route |-> (ctr_att == lo_l_att && ctr_mute == lo_l_mute &&
                   lfe_att == lo_r_att && lfe_mute == lo_r_mute));

  // R9
  other_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_idx != 8'h02) |-> (rd_data == '0));
endmodule

bind volmute_reg volmute_reg_chk u_chk (.*);

// File: tb/volmute_reg_test.sv
module volmute_reg_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en;
  logic [7:0]  wr_idx;
  logic [15:0] wr_data;
  logic [7:0]  rd_idx;
  logic [15:0] rd_data;
  logic        split_mute, ext_route;
  logic [4:0]  lo_l_att, lo_r_att, ctr_att, lfe_att;
  logic        lo_l_mute, lo_r_mute, ctr_mute, lfe_mute;

  int total = 0;
  int bad = 0;

  always #5 clk = ~clk;

  volmute_reg uut (.*);

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] idx, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_idx = idx; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  function automatic logic [15:0] lo_pack();
    return {4'h0, lo_l_mute, lo_l_att, 1'b0, lo_r_mute, lo_r_att};
  endfunction

  function automatic logic [15:0] ext_pack();
    return {4'h0, ctr_mute, ctr_att, 1'b0, lfe_mute, lfe_att};
  endfunction

  task automatic t_reset();
    rd_idx = 8'h02; #1;
    chk("R1 reset readback", rd_data, 16'h8000);
    chk("R1 reset line-out muted", lo_pack(), {4'h0, 1'b1, 5'd31, 1'b0, 1'b1, 5'd31});
  endtask

  task automatic t_basic();
    split_mute = 1'b1;
    wr(8'h02, 16'h0000 | (16'd7 << 8) | 16'd20);
    #1;
    chk("R2 readback fields", rd_data, 16'h0714);
    chk("R7 unmuted codes", lo_pack(), {4'h0, 1'b0, 5'd7, 1'b0, 1'b0, 5'd20});
    wr(8'h02, 16'h4040 | 16'h0a03);
    #1;
    chk("R2 bits 14 and 6 read zero", rd_data, 16'h0a03);
  endtask

  task automatic t_fold();
    split_mute = 1'b1;
    wr(8'h02, 16'h2005);
    #1;
    chk("R3 left fold readback", rd_data, 16'h1f05);
    chk("R3 left fold code", {11'h0, lo_l_att}, 16'd31);
    wr(8'h02, 16'h0321);
    #1;
    chk("R3 right fold readback", rd_data, 16'h031f);
    chk("R3 right fold code", {11'h0, lo_r_att}, 16'd31);
  endtask

  task automatic t_split_readback();
    split_mute = 1'b1;
    wr(8'h02, 16'h0084);
    #1;
    chk("R4 d7 visible in split", rd_data, 16'h0084);
    chk("R6 right only muted", lo_pack(), {4'h0, 1'b0, 5'd0, 1'b0, 1'b1, 5'd31});
    split_mute = 1'b0; #1;
    chk("R4 d7 hidden in joint", rd_data, 16'h0004);
    chk("R5 d7 no effect", lo_pack(), {4'h0, 1'b0, 5'd0, 1'b0, 1'b0, 5'd4});
    split_mute = 1'b1; #1;
    chk("R4 d7 reappears", rd_data, 16'h0084);
  endtask

  task automatic t_joint();
    split_mute = 1'b0;
    wr(8'h02, 16'h8306);
    #1;
    chk("R5 global mute both", lo_pack(), {4'h0, 1'b1, 5'd31, 1'b0, 1'b1, 5'd31});
    split_mute = 1'b1; #1;
    chk("R6 d15 left only", lo_pack(), {4'h0, 1'b1, 5'd31, 1'b0, 1'b0, 5'd6});
    wr(8'h02, 16'h8386);
    #1;
    chk("R6 both separate mutes", lo_pack(), {4'h0, 1'b1, 5'd31, 1'b0, 1'b1, 5'd31});
  endtask

  task automatic t_ext();
    split_mute = 1'b1;
    wr(8'h02, 16'h0b11);
    ext_route = 1'b0; #1;
    chk("R8 ext off defaults", ext_pack(), 16'h0000);
    ext_route = 1'b1; #1;
    chk("R8 ext follows", ext_pack(), {4'h0, 1'b0, 5'd11, 1'b0, 1'b0, 5'd17});
    wr(8'h02, 16'h0b91);
    #1;
    chk("R8 lfe follows right mute", ext_pack(), {4'h0, 1'b0, 5'd11, 1'b0, 1'b1, 5'd31});
    ext_route = 1'b0;
  endtask

  task automatic t_other_idx();
    split_mute = 1'b1;
    wr(8'h02, 16'h0c0d);
    wr(8'h04, 16'h9fff);
    wr(8'h03, 16'hffff);
    rd_idx = 8'h02; #1;
    chk("R9 other writes ignored", rd_data, 16'h0c0d);
    chk("R9 outputs unchanged", lo_pack(), {4'h0, 1'b0, 5'd12, 1'b0, 1'b0, 5'd13});
    rd_idx = 8'h04; #1;
    chk("R9 other read zero", rd_data, 16'h0000);
    rd_idx = 8'h02;
  endtask

  initial begin
    #20000;
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_idx = '0; wr_data = '0;
    rd_idx = 8'h02; split_mute = 1'b0; ext_route = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_fold();
    t_split_readback();
    t_joint();
    t_ext();
    t_other_idx();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule